// File: doc/BRIEF.md
# Low-Speed USB Bit Receiver

This block turns the two wires of a low-speed USB bus, sampled by a clock eight times faster than the 1.5 Mb/s bit rate, into a stream of received bytes. Both wires pass through a two-flop synchroniser. A phase counter then places one sample near the centre of each bit and restarts whenever D- changes level. The sample point therefore follows the sender's clock even when the two clocks differ slightly.

A control state machine hunts for the start of a packet, checks that the synchronisation field ends in two K bits, and then receives the packet. While it receives, the datapath decodes NRZI, drops stuffed bits and builds bytes least significant bit first. Each complete byte appears on `rx_byte` with a one-cycle `rx_valid` strobe. The packet ends either on a confirmed single-ended-zero (SE0) or on overflow, when a byte arrives beyond the configured limit. In both cases the block flags the event and goes back to hunting. PID, CRC and token meaning belong to the logic downstream.

States: `ST_HUNT` (idle, waiting for D- to fall from J to K), `ST_CHECK_K` (confirm that the line is K at the centre of the first bit), `ST_SECOND_K` (expect another K one bit later), `ST_RECEIVE` (decode the packet). Transitions: hunt→check on a falling D- edge; check→second on a K sample, check→hunt otherwise; second→receive on a K sample, second→hunt otherwise; receive→hunt on a second consecutive SE0 sample (end of packet) or on a byte beyond the limit (overflow).

Top module: `lsusb_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_eop`, `rx_overflow` and `rx_active` are 0 and `rx_byte` is 0x00.
- R2: The receiver becomes active only after a falling D- edge, followed by K (D+=1, D-=0) at two successive bit centres. `rx_active` is 1 from the end of sync until end of packet or overflow, and is 1 whenever `rx_valid` is 1.
- R3: If the bit after the first K is J (or anything other than K), the attempt is dropped and no byte or flag is produced. A single K bit followed by J leaves `rx_active` at 0.
- R4: NRZI decoding gives 1 when the sampled D- level matches the previous bit and 0 when it differs. The first data bit is compared against the final K of sync.
- R5: After six consecutive decoded 1s, which may span a byte boundary, the next bit is discarded and the run count restarts.
- R6: Bits fill a byte least significant bit first. After the eighth kept bit, `rx_byte` holds the byte and `rx_valid` is 1 for one cycle.
- R7: A sample with D+ and D- both 0 is SE0. Two consecutive SE0 samples raise `rx_eop` for one cycle and drop `rx_active`. A packet with no data bytes still ends this way.
- R8: A single SE0 sample that is followed by a non-SE0 sample is dropped. It is neither decoded nor counted, and later bytes are unaffected.
- R9: With limit `MAX_BYTES`, bytes 1 to `MAX_BYTES` are delivered. Completing byte `MAX_BYTES`+1 delivers nothing, raises `rx_overflow` for one cycle and returns to hunting without `rx_eop`. Exactly `MAX_BYTES` bytes end normally.
- R10: The sample point restarts on every D- transition. Packets whose bits last 7 or 9 clock cycles are received correctly as long as D- toggles on every bit.
- R11: At most one of `rx_valid`, `rx_eop`, `rx_overflow` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 8x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_in | input | 1 | D+ line, asynchronous |
| dm_in | input | 1 | D- line, asynchronous |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe, `rx_byte` is new |
| rx_eop | output | 1 | One-cycle end-of-packet flag |
| rx_overflow | output | 1 | One-cycle overflow flag, packet aborted |
| rx_active | output | 1 | Packet reception in progress |

## Verification
A wrong NRZI level or a wrong run count in the datapath shows up within one byte time as a wrong value on `rx_byte`, or as a byte that arrives one bit early or late. A stuck or misplaced sample counter shows up within a few bits when the 7- and 9-cycle packets are received, because the sample point then drifts across a bit edge. A state machine that leaves the receive state at the wrong time shows up within one bit of the event, as a missing or extra `rx_eop` or `rx_overflow` pulse or as `rx_active` still high when the packet has ended.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;
    localparam int BYTE_W    = 8;
    localparam int STUFF_RUN = 6;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_CHECK_K,
        ST_SECOND_K,
        ST_RECEIVE
    } lsrx_state_e;
endpackage

// File: rtl/lsrx_sync.sv
module lsrx_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lsrx_phase.sv
// Sample-point generator (R10): restarts on every D- change, ticks near bit centre.
module lsrx_phase #(
    parameter int OVS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dm_s,
    output logic tick,
    output logic dm_fall
);
    localparam int PH_W = $clog2(OVS);
    localparam logic [PH_W-1:0] PH_LAST   = PH_W'(OVS - 1);
    localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(OVS / 2 - 1);

    logic            dm_d;
    logic [PH_W-1:0] ph;
    logic            dm_edge;

    assign dm_edge = dm_s ^ dm_d;
    assign dm_fall = dm_d & ~dm_s;
    assign tick    = (ph == PH_SAMPLE) && !dm_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dm_d <= 1'b1;
            ph   <= '0;
        end else begin
            dm_d <= dm_s;
            if (dm_edge)           ph <= PH_W'(1);
            else if (ph == PH_LAST) ph <= '0;
            else                   ph <= ph + PH_W'(1);
        end
    end
endmodule

// File: rtl/lsrx_decode.sv
// NRZI decoder (R4), stuffed-bit removal (R5), LSB-first byte assembly (R6).
module lsrx_decode
    import lsrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bit_en,
    input  logic              line_lvl,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_out
);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              last_lvl;
    logic [RUN_W-1:0]  ones;
    logic [CNT_W-1:0]  nbits;
    logic [BYTE_W-2:0] shreg;
    logic              bit_val;
    logic              stuffed;

    assign bit_val   = (line_lvl == last_lvl);
    assign stuffed   = (ones == RUN_W'(STUFF_RUN));
    assign byte_out  = {bit_val, shreg};
    assign byte_done = bit_en && !stuffed && (nbits == CNT_W'(BYTE_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_lvl <= 1'b0;
            ones     <= '0;
            nbits    <= '0;
            shreg    <= '0;
        end else if (start) begin
            last_lvl <= 1'b0;
            ones     <= '0;
            nbits    <= '0;
        end else if (bit_en) begin
            last_lvl <= line_lvl;
            if (stuffed) begin
                ones <= '0;
            end else begin
                ones  <= bit_val ? ones + RUN_W'(1) : '0;
                shreg <= byte_out[BYTE_W-1:1];
                nbits <= nbits + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/lsusb_rx.sv
module lsusb_rx
    import lsrx_pkg::*;
#(
    parameter int OVS       = 8,
    parameter int SYNC_FF   = 2,
    parameter int MAX_BYTES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dp_in,
    input  logic       dm_in,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       rx_eop,
    output logic       rx_overflow,
    output logic       rx_active
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    logic [1:0]        lines_s;
    logic              dp_s, dm_s;
    logic              tick, dm_fall;
    logic              is_k, is_se0;
    logic              se0_seen;
    logic [CNT_W-1:0]  nbytes;
    logic              over;
    logic              dec_start, bit_en, byte_done;
    logic [BYTE_W-1:0] byte_out;
    logic              end_of_pkt;
    lsrx_state_e       state, state_nx;

    lsrx_sync #(.WIDTH(2), .STAGES(SYNC_FF), .RST_VAL(2'b10)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({dm_in, dp_in}), .q(lines_s)
    );
    assign dm_s = lines_s[1];
    assign dp_s = lines_s[0];

    lsrx_phase #(.OVS(OVS)) u_phase (
        .clk(clk), .rst_n(rst_n), .dm_s(dm_s), .tick(tick), .dm_fall(dm_fall)
    );

    assign is_k       = dp_s & ~dm_s;
    assign is_se0     = ~dp_s & ~dm_s;
    assign over       = (nbytes == CNT_W'(MAX_BYTES));
    assign dec_start  = (state == ST_SECOND_K);
    assign bit_en     = tick && (state == ST_RECEIVE) && !is_se0;   // R8: SE0 never decoded
    assign end_of_pkt = tick && (state == ST_RECEIVE) && is_se0 && se0_seen;  // R7

    lsrx_decode u_dec (
        .clk(clk), .rst_n(rst_n), .start(dec_start), .bit_en(bit_en),
        .line_lvl(dm_s), .byte_done(byte_done), .byte_out(byte_out)
    );

    // Next-state logic (R2, R3, R7, R9)
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:     if (dm_fall) state_nx = ST_CHECK_K;
            ST_CHECK_K:  if (tick)    state_nx = is_k ? ST_SECOND_K : ST_HUNT;
            ST_SECOND_K: if (tick)    state_nx = is_k ? ST_RECEIVE  : ST_HUNT;
            ST_RECEIVE:  if (end_of_pkt || (byte_done && over)) state_nx = ST_HUNT;
            default:     state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // Packet bookkeeping: SE0 history and byte count (R8, R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            se0_seen <= 1'b0;
            nbytes   <= '0;
        end else if (state != ST_RECEIVE) begin
            se0_seen <= 1'b0;
            nbytes   <= '0;
        end else begin
            if (tick)      se0_seen <= is_se0;
            if (byte_done && !over) nbytes <= nbytes + CNT_W'(1);
        end
    end

    // Outputs (R1, R6, R7, R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte     <= '0;
            rx_valid    <= 1'b0;
            rx_eop      <= 1'b0;
            rx_overflow <= 1'b0;
        end else begin
            rx_valid    <= byte_done && !over;
            rx_eop      <= end_of_pkt;
            rx_overflow <= byte_done && over;
            if (byte_done && !over) rx_byte <= byte_out;
        end
    end

    assign rx_active = (state == ST_RECEIVE);
endmodule

// File: rtl/lsusb_rx_checker.sv
module lsusb_rx_checker #(
    parameter int CNT_W = 4,
    parameter int LIMIT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_eop,
    input logic             rx_overflow,
    input logic             rx_active,
    input logic [CNT_W-1:0] nbytes
);
    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, rx_eop, rx_overflow}));

    assert_valid_in_packet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_active);

    assert_eop_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eop |-> (!rx_active && $past(rx_active)));

    assert_overflow_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |-> (!rx_active && $past(rx_active)));

    assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nbytes <= CNT_W'(LIMIT));

    assert_count_fresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_active) |-> (nbytes == '0));
endmodule

bind lsusb_rx lsusb_rx_checker #(.CNT_W(CNT_W), .LIMIT(MAX_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eop(rx_eop),
    .rx_overflow(rx_overflow), .rx_active(rx_active), .nbytes(nbytes)
);

// File: tb/tb_lsusb_rx.sv
`timescale 1ns/1ps
module tb_lsusb_rx;
    localparam int OVS   = 8;
    localparam int LIMIT = 8;
    localparam logic [7:0] SYNC_DM = 8'b0010_1010;  // D- level per sync bit, first bit at [0]

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp = 1'b0;
    logic       dm = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid, rx_eop, rx_overflow, rx_active;

    int checks = 0;
    int fails  = 0;
    int eop_cnt = 0;
    int ovf_cnt = 0;
    logic [7:0] exp_q[$];
    logic [7:0] pkt[$];

    always #2.5 clk = ~clk;

    lsusb_rx #(.OVS(OVS), .SYNC_FF(2), .MAX_BYTES(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .dp_in(dp), .dm_in(dm),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_eop(rx_eop),
        .rx_overflow(rx_overflow), .rx_active(rx_active)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: scoreboard pop and compare (R6, R2)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R6 unexpected byte: act=%h exp=none", rx_byte);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (rx_byte !== e) begin
                        fails++;
                        $display("FAIL R6 byte: act=%h exp=%h", rx_byte, e);
                    end
                end
                chk("R2", "active during byte", int'(rx_active), 1);
            end
            if (rx_eop)      eop_cnt++;
            if (rx_overflow) ovf_cnt++;
        end
    end

    task automatic put(input logic p, input logic m, input int len);
        dp = p;
        dm = m;
        repeat (len) @(negedge clk);
    endtask

    // Driver: sync, NRZI + stuffing, optional lone SE0, two-bit SE0, idle
    task automatic send_pkt(input int len, input bit glitch);
        logic cur;
        int   ones;
        for (int s = 0; s < 8; s++) put(~SYNC_DM[s], SYNC_DM[s], len);
        cur  = 1'b0;
        ones = 0;
        for (int i = 0; i < pkt.size(); i++) begin
            if (i < LIMIT) exp_q.push_back(pkt[i]);
            for (int b = 0; b < 8; b++) begin
                if (!pkt[i][b]) cur = ~cur;
                put(~cur, cur, len);
                ones = pkt[i][b] ? ones + 1 : 0;
                if (ones == 6) begin
                    cur  = ~cur;
                    put(~cur, cur, len);
                    ones = 0;
                end
            end
            if (glitch && i == 0) put(1'b0, 1'b0, len);
        end
        put(1'b0, 1'b0, len);
        put(1'b0, 1'b0, len);
        put(1'b0, 1'b1, len * 6);
    endtask

    task automatic end_check(input string tag, input int eop0, input int ovf0,
                             input int d_eop, input int d_ovf);
        chk(tag, "eop pulses", eop_cnt - eop0, d_eop);
        chk(tag, "overflow pulses", ovf_cnt - ovf0, d_ovf);
        chk(tag, "bytes missing", exp_q.size(), 0);
        chk(tag, "active after end", int'(rx_active), 0);
        exp_q.delete();
    endtask

    initial begin
        int e0, o0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rx_valid", int'(rx_valid), 0);
        chk("R1", "rx_eop", int'(rx_eop), 0);
        chk("R1", "rx_overflow", int'(rx_overflow), 0);
        chk("R1", "rx_active", int'(rx_active), 0);
        chk("R1", "rx_byte", int'(rx_byte), 0);
        put(1'b0, 1'b1, 40);

        // R4 R6 R7: mixed bytes
        e0 = eop_cnt; o0 = ovf_cnt;
        pkt = '{8'h01, 8'h80, 8'hA5, 8'h3C};
        send_pkt(OVS, 1'b0);
        end_check("R7", e0, o0, 1, 0);

        // R5: long runs of ones across byte boundaries
        e0 = eop_cnt; o0 = ovf_cnt;
        pkt = '{8'hFF, 8'hFF, 8'h7E, 8'h3F, 8'hFC};
        send_pkt(OVS, 1'b0);
        end_check("R5", e0, o0, 1, 0);

        // R8: lone SE0 bit inside the packet
        e0 = eop_cnt; o0 = ovf_cnt;
        pkt = '{8'h12, 8'h34, 8'hC3};
        send_pkt(OVS, 1'b1);
        end_check("R8", e0, o0, 1, 0);

        // R3: one K then J, no packet
        e0 = eop_cnt; o0 = ovf_cnt;
        put(1'b1, 1'b0, OVS);
        put(1'b0, 1'b1, OVS * 8);
        end_check("R3", e0, o0, 0, 0);

        // R7: sync directly followed by SE0
        e0 = eop_cnt; o0 = ovf_cnt;
        pkt.delete();
        send_pkt(OVS, 1'b0);
        end_check("R7", e0, o0, 1, 0);

        // R9: exactly LIMIT bytes ends normally
        e0 = eop_cnt; o0 = ovf_cnt;
        pkt.delete();
        for (int i = 0; i < LIMIT; i++) pkt.push_back(8'(i * 29 + 3));
        send_pkt(OVS, 1'b0);
        end_check("R9", e0, o0, 1, 0);

        // R9: LIMIT+1 bytes overflows
        e0 = eop_cnt; o0 = ovf_cnt;
        pkt.delete();
        for (int i = 0; i <= LIMIT; i++) pkt.push_back(8'(i * 17 + 5));
        send_pkt(OVS, 1'b0);
        end_check("R9", e0, o0, 0, 1);

        // R10: slow and fast bit periods with D- toggling every bit
        e0 = eop_cnt; o0 = ovf_cnt;
        pkt = '{8'h00, 8'h00, 8'h00};
        send_pkt(OVS + 1, 1'b0);
        end_check("R10", e0, o0, 1, 0);

        e0 = eop_cnt; o0 = ovf_cnt;
        pkt = '{8'h00, 8'h00};
        send_pkt(OVS - 1, 1'b0);
        end_check("R10", e0, o0, 1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 watchdog: act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule